// File: doc/BRIEF.md
# Multi-Slot Interrupt Aggregation Controller

This block merges the interrupt requests of four module slots, each slot offering two request lines, into a single active-high host interrupt. Every slot owns an 8-bit control byte that enables each of its two lines and chooses whether that line is treated as edge-sensitive or level-sensitive. A 16-bit status word keeps the pending request bits, four per-slot timeout flags and four error flags.

A level-sensitive line that is pending holds the host interrupt high until software clears it. It can be cleared by a write-one-to-clear to the status word, by an acknowledge that the slot's interrupt space produces, or by the request line dropping. An edge-sensitive line that becomes pending gives a single one-clock pulse on the host interrupt. Its pending bit stays visible in status but never holds the output. Timeout and error flags are set by external event inputs and are only stored here. Timeouts are cleared by writing a one. Error flags are cleared only by reset.

Top module: `slot_irq_merge`

## Requirements
- R1: After synchronous reset, `host_irq` is 0 and every register reads 0: the four control bytes and the status word.
- R2: The control byte of slot n (n = 0..3) is written and read at byte offset 0x02 + 2n. Only wdata[7:0] is stored, and bits 15:8 read back as 0. Bit 6+k enables line k and bit 4+k selects edge mode for line k. Bits 0 to 3 are stored only.
- R3: Offsets 0x00 and 0x0A read 0, and writes to them change no register. Offset 0x0C reads the status word. Any read returns its data on `rdata` one clock after `rd_en`.
- R4: For an enabled line of slot n, line k, a rising request sets status bit 2n+k and a falling request clears it. A clear and a rise in the same cycle leave the bit set.
- R5: A request change on a line whose enable bit is 0 is ignored, and its status bit does not change.
- R6: When an enabled edge-mode line rises and its status bit goes from 0 to 1, `host_irq` is high for exactly one clock, in the cycle after the rise is sampled.
- R7: `host_irq` is held high while any status bit 2n+k is set for a line in level mode. Bits of edge-mode lines are masked out. The output drops in the cycle after the last such bit clears.
- R8: A status write with a 1 in bit 2n+k clears that pending bit. A 1 in bit 12+n clears timeout n. Writes to bits 11:8 have no effect.
- R9: An acknowledge to slot n at interrupt offset 0 clears pending bit 2n, and at offset 2 it clears bit 2n+1. It does so only if that line is in level mode. An acknowledge to an edge-mode line or to any other offset changes nothing.
- R10: `tmo_i[n]` sets status bit 12+n and `err_i[n]` sets bit 8+n. A set wins over a clearing write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 8 | Request lines, bit 2n+k is slot n line k |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid the cycle after rd_en |
| ack_en | input | 1 | Interrupt-space acknowledge strobe |
| ack_slot | input | 2 | Slot being acknowledged |
| ack_ofs | input | 6 | Interrupt-space offset of the acknowledge |
| tmo_i | input | 4 | Per-slot timeout event |
| err_i | input | 4 | Per-slot error event |
| host_irq | output | 1 | Merged host interrupt, active high |

## Verification
Every state change lands on the first rising edge that samples the stimulus. The status word, the control bytes, the held level output and the edge pulse are all visible one cycle after a request change, a write, an acknowledge or an event input. A read returns data one cycle after `rd_en`. The bench drives inputs on falling edges and samples on the next falling edge, so each check falls in the cycle where the result is due. The edge pulse is checked both in its single active cycle and in the cycle after it, where it must be low.

// File: rtl/slot_irq_pkg.sv
package slot_irq_pkg;

    localparam int NSLOT   = 4;
    localparam int NLINE   = 2;
    localparam int NREQ    = NSLOT * NLINE;
    localparam int SLOT_W  = $clog2(NSLOT);
    localparam int REG_W   = 16;
    localparam int CTRL_W  = 8;
    localparam int OFS_W   = 8;
    localparam int IOFS_W  = 6;

    localparam logic [OFS_W-1:0] OFS_REV   = 8'h00;
    localparam logic [OFS_W-1:0] OFS_SLOT0 = 8'h02;
    localparam logic [OFS_W-1:0] OFS_RSV   = 8'h0A;
    localparam logic [OFS_W-1:0] OFS_STAT  = 8'h0C;

    // control byte, MSB first
    typedef struct packed {
        logic en1;
        logic en0;
        logic edge1;
        logic edge0;
        logic err_ie;
        logic tmo_ie;
        logic recover;
        logic clk_sel;
    } slot_ctrl_t;

    // status word, MSB first: timeouts, errors, pending pairs
    typedef struct packed {
        logic [NSLOT-1:0] tmo;
        logic [NSLOT-1:0] err;
        logic [NREQ-1:0]  pend;
    } stat_t;

    function automatic logic [OFS_W-1:0] slot_ofs(input int s);
        return OFS_SLOT0 + OFS_W'(2 * s);
    endfunction

    function automatic logic line_en(input slot_ctrl_t c, input int l);
        return (l == 0) ? c.en0 : c.en1;
    endfunction

    function automatic logic line_edge(input slot_ctrl_t c, input int l);
        return (l == 0) ? c.edge0 : c.edge1;
    endfunction

endpackage

// File: rtl/slot_irq_ctrl_regs.sv
module slot_irq_ctrl_regs
    import slot_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [OFS_W-1:0] addr,
    input  logic [CTRL_W-1:0] wdata_lo,
    input  stat_t            stat_i,
    output logic [NREQ-1:0]  en_mask,
    output logic [NREQ-1:0]  edge_mask,
    output logic [REG_W-1:0] rdata
);

    slot_ctrl_t ctrl_q [NSLOT];
    logic [REG_W-1:0] rd_mux;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                ctrl_q[s] <= '0;
            else if (wr_en && addr == slot_ofs(s))
                ctrl_q[s] <= slot_ctrl_t'(wdata_lo);
        end
        for (genvar l = 0; l < NLINE; l++) begin : g_line
            assign en_mask[NLINE*s+l]   = line_en(ctrl_q[s], l);
            assign edge_mask[NLINE*s+l] = line_edge(ctrl_q[s], l);
        end
    end

    always_comb begin
        rd_mux = '0;
        if (addr == OFS_STAT)
            rd_mux = stat_i;
        for (int s = 0; s < NSLOT; s++)
            if (addr == slot_ofs(s))
                rd_mux = {{(REG_W-CTRL_W){1'b0}}, ctrl_q[s]};
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (rd_en)
            rdata <= rd_mux;
    end

endmodule

// File: rtl/slot_irq_status.sv
module slot_irq_status
    import slot_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NREQ-1:0]   req_i,
    input  logic [NREQ-1:0]   en_mask,
    input  logic [NREQ-1:0]   edge_mask,
    input  logic              stat_wr,
    input  logic [NREQ-1:0]   pend_clr,
    input  logic [NSLOT-1:0]  tmo_clr,
    input  logic              ack_en,
    input  logic [SLOT_W-1:0] ack_slot,
    input  logic [IOFS_W-1:0] ack_ofs,
    input  logic [NSLOT-1:0]  tmo_i,
    input  logic [NSLOT-1:0]  err_i,
    output stat_t             stat_q,
    output logic [NREQ-1:0]   fire
);

    logic [NREQ-1:0] req_q;
    stat_t           stat_n;

    always_ff @(posedge clk) begin
        if (rst)
            req_q <= '0;
        else
            req_q <= req_i;
    end

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        for (genvar l = 0; l < NLINE; l++) begin : g_line
            localparam int B = NLINE * s + l;
            logic rise, fall, ack_hit, wclr;
            assign rise    = en_mask[B] & req_i[B] & ~req_q[B];
            assign fall    = en_mask[B] & ~req_i[B] & req_q[B];
            assign ack_hit = ack_en && ack_slot == SLOT_W'(s)
                             && ack_ofs == IOFS_W'(2 * l) && !edge_mask[B];
            assign wclr    = stat_wr & pend_clr[B];
            assign stat_n.pend[B] = rise | (stat_q.pend[B] & ~fall & ~ack_hit & ~wclr);
            assign fire[B] = rise & edge_mask[B] & ~stat_q.pend[B];
        end
        assign stat_n.tmo[s] = tmo_i[s] | (stat_q.tmo[s] & ~(stat_wr & tmo_clr[s]));
        assign stat_n.err[s] = err_i[s] | stat_q.err[s];
    end

    always_ff @(posedge clk) begin
        if (rst)
            stat_q <= '0;
        else
            stat_q <= stat_n;
    end

endmodule

// File: rtl/slot_irq_out.sv
module slot_irq_out
    import slot_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NREQ-1:0] fire,
    input  logic [NREQ-1:0] pend,
    input  logic [NREQ-1:0] edge_mask,
    output logic            pulse_q,
    output logic            host_irq
);

    logic lvl_hold;

    always_ff @(posedge clk) begin
        if (rst)
            pulse_q <= 1'b0;
        else
            pulse_q <= |fire;
    end

    assign lvl_hold = |(pend & ~edge_mask);
    assign host_irq = pulse_q | lvl_hold;

endmodule

// File: rtl/slot_irq_merge.sv
module slot_irq_merge
    import slot_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NREQ-1:0]   req_i,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [OFS_W-1:0]  addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    input  logic              ack_en,
    input  logic [SLOT_W-1:0] ack_slot,
    input  logic [IOFS_W-1:0] ack_ofs,
    input  logic [NSLOT-1:0]  tmo_i,
    input  logic [NSLOT-1:0]  err_i,
    output logic              host_irq
);

    logic [NREQ-1:0] en_mask;
    logic [NREQ-1:0] edge_mask;
    logic [NREQ-1:0] fire;
    logic            pulse_q;
    logic            stat_wr;
    stat_t           stat_q;

    assign stat_wr = wr_en && addr == OFS_STAT;

    slot_irq_ctrl_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .wdata_lo  (wdata[CTRL_W-1:0]),
        .stat_i    (stat_q),
        .en_mask   (en_mask),
        .edge_mask (edge_mask),
        .rdata     (rdata)
    );

    slot_irq_status u_stat (
        .clk       (clk),
        .rst       (rst),
        .req_i     (req_i),
        .en_mask   (en_mask),
        .edge_mask (edge_mask),
        .stat_wr   (stat_wr),
        .pend_clr  (wdata[NREQ-1:0]),
        .tmo_clr   (wdata[REG_W-1:REG_W-NSLOT]),
        .ack_en    (ack_en),
        .ack_slot  (ack_slot),
        .ack_ofs   (ack_ofs),
        .tmo_i     (tmo_i),
        .err_i     (err_i),
        .stat_q    (stat_q),
        .fire      (fire)
    );

    slot_irq_out u_out (
        .clk       (clk),
        .rst       (rst),
        .fire      (fire),
        .pend      (stat_q.pend),
        .edge_mask (edge_mask),
        .pulse_q   (pulse_q),
        .host_irq  (host_irq)
    );

endmodule

// File: rtl/slot_irq_merge_chk.sv
module slot_irq_merge_chk
    import slot_irq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [NREQ-1:0]  req_i,
    input logic             wr_en,
    input logic             rd_en,
    input logic [OFS_W-1:0] addr,
    input logic [REG_W-1:0] wdata,
    input logic [REG_W-1:0] rdata,
    input logic [NSLOT-1:0] tmo_i,
    input logic [NSLOT-1:0] err_i,
    input stat_t            stat_q,
    input logic [NREQ-1:0]  en_mask,
    input logic [NREQ-1:0]  edge_mask,
    input logic             pulse_q
);

    // R3
    fixed_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rd_en && (addr == OFS_REV || addr == OFS_RSV)) |-> rdata == '0);

    // R5
    disabled_line_chk: assert property (@(posedge clk) disable iff (rst)
        ((stat_q.pend & ~$past(stat_q.pend) & ~$past(en_mask)) == '0));

    // R6
    pulse_src_chk: assert property (@(posedge clk) disable iff (rst)
        pulse_q |-> $past(|(req_i & edge_mask & en_mask)));

    // R8
    tmo_w1c_chk: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en && addr == OFS_STAT) |->
            ((stat_q.tmo & $past(wdata[REG_W-1:REG_W-NSLOT] & ~tmo_i)) == '0));

    // R8
    err_keep_chk: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en && addr == OFS_STAT && |wdata[11:8]) |->
            stat_q.err == ($past(stat_q.err) | $past(err_i)));

endmodule

bind slot_irq_merge slot_irq_merge_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_i     (req_i),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .tmo_i     (tmo_i),
    .err_i     (err_i),
    .stat_q    (stat_q),
    .en_mask   (en_mask),
    .edge_mask (edge_mask),
    .pulse_q   (pulse_q)
);

// File: tb/slot_irq_merge_tb_top.sv
`timescale 1ns/1ps
module slot_irq_merge_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  req_i = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        ack_en = 1'b0;
    logic [1:0]  ack_slot = '0;
    logic [5:0]  ack_ofs = '0;
    logic [3:0]  tmo_i = '0;
    logic [3:0]  err_i = '0;
    logic        host_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    slot_irq_merge dut_i (
        .clk(clk), .rst(rst), .req_i(req_i), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .ack_en(ack_en),
        .ack_slot(ack_slot), .ack_ofs(ack_ofs), .tmo_i(tmo_i), .err_i(err_i),
        .host_irq(host_irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        tick(); rst = 1'b1; req_i = '0; tmo_i = '0; err_i = '0;
        tick(); tick(); rst = 1'b0;
        tick();
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [15:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        tick();
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic reg_rd(input logic [7:0] a, output logic [15:0] d);
        rd_en = 1'b1; addr = a;
        tick();
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic ack(input logic [1:0] s, input logic [5:0] o);
        ack_en = 1'b1; ack_slot = s; ack_ofs = o;
        tick();
        ack_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        do_reset();
        check("R1 host_irq", {15'd0, host_irq}, 16'h0);
        for (int s = 0; s < 4; s++) begin
            reg_rd(8'(2 + 2 * s), d);
            check("R1 ctrl", d, 16'h0);
        end
        reg_rd(8'h0C, d);
        check("R1 status", d, 16'h0);
    endtask

    task automatic t_ctrl_rw();
        logic [15:0] d;
        do_reset();
        for (int s = 0; s < 4; s++) reg_wr(8'(2 + 2 * s), 16'hFF00 | 16'(8'h0F + 8'(s * 16)));
        for (int s = 0; s < 4; s++) begin
            reg_rd(8'(2 + 2 * s), d);
            check("R2 ctrl readback", d, 16'(8'h0F + 8'(s * 16)));
        end
    endtask

    task automatic t_fixed();
        logic [15:0] d;
        do_reset();
        reg_wr(8'h04, 16'h0055);
        reg_wr(8'h00, 16'hFFFF);
        reg_wr(8'h0A, 16'hFFFF);
        reg_rd(8'h00, d); check("R3 revision", d, 16'h0);
        reg_rd(8'h0A, d); check("R3 reserved", d, 16'h0);
        reg_rd(8'h04, d); check("R3 ctrl untouched", d, 16'h0055);
        reg_rd(8'h0C, d); check("R3 status untouched", d, 16'h0);
    endtask

    task automatic t_disabled();
        logic [15:0] d;
        do_reset();
        reg_wr(8'h02, 16'h0030); // edge bits only, no enables
        req_i[0] = 1'b1; req_i[1] = 1'b1;
        tick();
        check("R5 host_irq", {15'd0, host_irq}, 16'h0);
        reg_rd(8'h0C, d); check("R5 status", d, 16'h0);
        req_i = '0;
    endtask

    task automatic t_level();
        logic [15:0] d;
        do_reset();
        reg_wr(8'h04, 16'h0040); // slot1 line0 enabled, level
        req_i[2] = 1'b1;
        tick();
        check("R7 level high", {15'd0, host_irq}, 16'h1);
        tick(); tick();
        check("R7 level held", {15'd0, host_irq}, 16'h1);
        reg_rd(8'h0C, d); check("R4 set bit 2", d, 16'h0004);
        req_i[2] = 1'b0;
        tick();
        check("R7 level drops", {15'd0, host_irq}, 16'h0);
        reg_rd(8'h0C, d); check("R4 fall clears", d, 16'h0);
    endtask

    task automatic t_edge();
        logic [15:0] d;
        do_reset();
        reg_wr(8'h06, 16'h00A0); // slot2 line1 enabled, edge
        req_i[5] = 1'b1;
        tick();
        check("R6 pulse", {15'd0, host_irq}, 16'h1);
        tick();
        check("R6 pulse one clock", {15'd0, host_irq}, 16'h0);
        reg_rd(8'h0C, d); check("R4 edge bit 5", d, 16'h0020);
        check("R7 edge masked", {15'd0, host_irq}, 16'h0);
        reg_wr(8'h04, 16'h0080); // slot1 line1 level
        req_i[3] = 1'b1;
        tick(); tick();
        check("R7 level with edge pending", {15'd0, host_irq}, 16'h1);
        req_i = '0;
    endtask

    task automatic t_w1c();
        logic [15:0] d;
        do_reset();
        reg_wr(8'h04, 16'h0040);
        req_i[2] = 1'b1; tick();
        tmo_i = 4'b1000; tick(); tmo_i = '0;
        err_i = 4'b0010; tick(); err_i = '0;
        reg_rd(8'h0C, d); check("R10 flags set", d, 16'h8204);
        reg_wr(8'h0C, 16'h8F04);
        check("R8 host drops", {15'd0, host_irq}, 16'h0);
        reg_rd(8'h0C, d); check("R8 w1c", d, 16'h0200);
        req_i = '0;
    endtask

    task automatic t_tmo_prio();
        logic [15:0] d;
        do_reset();
        tmo_i = 4'b0001;
        reg_wr(8'h0C, 16'h1000);
        tmo_i = '0;
        reg_rd(8'h0C, d); check("R10 set wins", d, 16'h1000);
        reg_wr(8'h0C, 16'h1000);
        reg_rd(8'h0C, d); check("R8 tmo cleared", d, 16'h0);
    endtask

    task automatic t_ack();
        logic [15:0] d;
        do_reset();
        reg_wr(8'h08, 16'h00E0); // slot3: line0 level, line1 edge
        req_i[6] = 1'b1; req_i[7] = 1'b1;
        tick();
        reg_rd(8'h0C, d); check("R4 both set", d, 16'h00C0);
        ack(2'd3, 6'd4);
        ack(2'd2, 6'd0);
        reg_rd(8'h0C, d); check("R9 other ofs/slot", d, 16'h00C0);
        ack(2'd3, 6'd0);
        check("R9 host drops", {15'd0, host_irq}, 16'h0);
        reg_rd(8'h0C, d); check("R9 level ack", d, 16'h0080);
        ack(2'd3, 6'd2);
        reg_rd(8'h0C, d); check("R9 edge ack ignored", d, 16'h0080);
        req_i = '0;
    endtask

    initial begin
        t_reset();
        t_ctrl_rw();
        t_fixed();
        t_disabled();
        t_level();
        t_edge();
        t_w1c();
        t_tmo_prio();
        t_ack();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule